// File: doc/BRIEF.md
# Retransmit-Capable FIFO Controller

This block is a single-clock FIFO with a storage array, read and write pointers, and four occupancy flags: empty, full, almost-empty and almost-full. A writer pushes words with a write enable and a reader pops them with a read enable. A word that is read appears on the read data output one clock after the read is accepted. The output keeps that word until the next accepted read.

The block can also replay what it holds. When the active-low retransmit input is sampled low, the read pointer goes back to physical location zero and the write pointer stays where it is. The flags are then recomputed from the rewound read pointer. Reads that follow return the earlier words again in their original order. After the replay they return any words written since.

A rewind is only meaningful while no more words than the depth have been written since the last master reset, because only then is location zero still the oldest word. A rewind is refused at any other time. It is also refused when the block is strapped as one stage of a depth chain. After an accepted rewind the block spends a fixed number of clocks recovering. During that time it raises a busy output and ignores both enables.

Top module: `fifo_rt_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears both pointers and the count of writes since reset, and sets `rd_data` to 0. After that edge `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and `busy`=0.
- R2: Words come out in the order they were written. `rd_data` changes only at the edge that accepts a read, and from that edge it shows the word that was read.
- R3: A write while `full`=1 is dropped, and so is a read while `empty`=1. A dropped read leaves `rd_data` unchanged. The occupancy never exceeds DEPTH.
- R4: With occupancy N = writes minus reads since the last rewind or reset, `empty` is (N==0), `full` is (N==DEPTH), `almost_empty` is (N<=AE_LEVEL) and `almost_full` is (N>=DEPTH-AF_LEVEL).
- R5: `rt_n` sampled low at an edge, with `chain_mode`=0 and at most DEPTH writes since reset, sets the read pointer to location 0. The next accepted read returns the first word written after reset.
- R6: From the edge that accepts a rewind, the flags reflect N equal to the number of writes since reset. The write pointer is unchanged.
- R7: After an accepted rewind, `busy` is 1 for exactly RECOVER_CYC cycles and then 0. Enables presented at the rewind edge or while `busy`=1 are ignored.
- R8: After the replayed words, reads return the words written after the rewind. `empty` rises once the read pointer reaches the write pointer.
- R9: A rewind requested after more than DEPTH writes since reset is ignored: no rewind and no `busy`.
- R10: A rewind requested while `chain_mode`=1 is ignored: no rewind and no `busy`.
- R11: A FIFO filled to DEPTH words can be read out in full, rewound, and read out in full again, repeatedly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Last word read |
| rt_n | input | 1 | Active-low retransmit request |
| chain_mode | input | 1 | 1 = block is one stage of a depth chain; retransmit disabled |
| busy | output | 1 | Recovery interval after a rewind is in progress |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy is DEPTH |
| almost_empty | output | 1 | Occupancy at or below AE_LEVEL |
| almost_full | output | 1 | Occupancy at or above DEPTH-AF_LEVEL |

## Verification
A read pointer that rewinds to the wrong location shows up on the very first read after `busy` falls, as the wrong word on `rd_data`. A write pointer that is disturbed by a rewind shows up as wrong flags in the cycle right after the rewind edge. A recovery counter that is off by one changes when `busy` falls. It also lets through a read or write the block should have ignored, and that shows as an early word or a shifted flag one cycle later. A write counter that is wrong makes a rewind be accepted or refused in error, and `busy` differs at the next edge.

// File: rtl/fifo_rt_pkg.sv
// Package: shared types for the retransmit FIFO controller.
// Assumes nothing beyond the standard language.
package fifo_rt_pkg;
    // Occupancy flags produced from the pointer difference.
    typedef struct packed {
        logic empty;
        logic full;
        logic almost_empty;
        logic almost_full;
    } occ_flags_t;
endpackage

// File: rtl/rt_recovery.sv
// Decides whether a retransmit request is honoured and times the
// recovery interval after it. Assumes RECOVER_CYC >= 1 and that rt_allowed
// comes from the registered write counter (no combinational loop).
module rt_recovery #(
    parameter int RECOVER_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rt_n,
    input  logic chain_mode,
    input  logic rt_allowed,
    output logic rt_fire,
    output logic blocked,
    output logic busy
);
    localparam int TW = $clog2(RECOVER_CYC + 1);

    logic [TW-1:0] timer_q;

    // Accept a rewind only when standalone and within the depth window.
    assign rt_fire = !rt_n && !chain_mode && rt_allowed;
    assign busy    = (timer_q != '0);
    assign blocked = rt_fire || busy;

    // Load the recovery timer on a rewind, otherwise count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
        end else if (rt_fire) begin
            timer_q <= TW'(RECOVER_CYC);
        end else if (timer_q != '0) begin
            timer_q <= timer_q - 1'b1;
        end
    end

    AST_BUSY_AFTER_RT: assert property (@(posedge clk) disable iff (!rst_n)
        rt_fire |=> busy); // R7
    AST_NO_BUSY_WHEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rt_fire) |=> !busy); // R9
endmodule

// File: rtl/rt_ptr_ctrl.sv
// Holds the read and write pointers and the saturating count of writes
// since master reset. Pointers carry one extra wrap bit, so their
// difference is the occupancy. Assumes DEPTH is a power of two.
module rt_ptr_ctrl #(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_req,
    input  logic                        rd_req,
    input  logic                        rt_fire,
    input  logic                        blocked,
    output logic                        wr_ok,
    output logic                        rd_ok,
    output logic [$clog2(DEPTH)-1:0]    waddr,
    output logic [$clog2(DEPTH)-1:0]    raddr,
    output logic [$clog2(DEPTH):0]      occupancy,
    output logic                        rt_allowed
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0] wptr_q, rptr_q, wcount_q;

    assign occupancy  = wptr_q - rptr_q;
    assign wr_ok      = wr_req && !blocked && (occupancy != DEPTH_C);
    assign rd_ok      = rd_req && !blocked && (occupancy != '0);
    assign waddr      = wptr_q[AW-1:0];
    assign raddr      = rptr_q[AW-1:0];
    assign rt_allowed = (wcount_q <= DEPTH_C);

    // Advance the write pointer and the saturating write count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q   <= '0;
            wcount_q <= '0;
        end else if (wr_ok) begin
            wptr_q <= wptr_q + 1'b1;
            if (wcount_q <= DEPTH_C) wcount_q <= wcount_q + 1'b1;
        end
    end

    // Advance the read pointer, or rewind it to location zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q <= '0;
        end else if (rt_fire) begin
            rptr_q <= '0;
        end else if (rd_ok) begin
            rptr_q <= rptr_q + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= DEPTH_C); // R3
    AST_RT_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        rt_fire |=> (occupancy == $past(wcount_q))); // R6
    AST_QUIET_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> $stable(wptr_q)); // R7
endmodule

// File: rtl/rt_flag_calc.sv
// Derives the four occupancy flags from the pointer difference.
// Assumes AE_LEVEL < DEPTH and AF_LEVEL < DEPTH.
module rt_flag_calc #(
    parameter int DEPTH    = 16,
    parameter int AE_LEVEL = 2,
    parameter int AF_LEVEL = 2
) (
    input  logic [$clog2(DEPTH):0]      occupancy,
    output fifo_rt_pkg::occ_flags_t     flags
);
    localparam int CW = $clog2(DEPTH) + 1;

    // Compare the occupancy against the fixed thresholds.
    always_comb begin
        flags.empty        = (occupancy == '0);
        flags.full         = (occupancy == CW'(DEPTH));
        flags.almost_empty = (occupancy <= CW'(AE_LEVEL));
        flags.almost_full  = (occupancy >= CW'(DEPTH - AF_LEVEL));
    end

    always_comb begin
        AST_FLAG_EXCL: assert (!(flags.empty && flags.full)); // R4
    end
endmodule

// File: rtl/rt_mem.sv
// Storage array with one write port and a registered read port. The read
// register updates only on an accepted read. Assumes the controller never
// reads and writes the same slot in the same cycle.
module rt_mem #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_ok,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     rd_ok,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] store_q [DEPTH];

    // Write an accepted word into its slot.
    always_ff @(posedge clk) begin
        if (wr_ok) store_q[waddr] <= wdata;
    end

    // Capture the addressed word on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_ok) begin
            rdata <= store_q[raddr];
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> $stable(rdata)); // R2
endmodule

// File: rtl/fifo_rt_ctrl.sv
// Top of the retransmit-capable FIFO controller. It connects the pointer
// control, the recovery timer, the flag logic and the storage. It assumes a
// single clock and a synchronous active-low master reset.
module fifo_rt_ctrl #(
    parameter int DATA_W      = 9,
    parameter int DEPTH       = 16,
    parameter int AE_LEVEL    = 2,
    parameter int AF_LEVEL    = 2,
    parameter int RECOVER_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rt_n,
    input  logic              chain_mode,
    output logic              busy,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int AW = $clog2(DEPTH);

    logic                    rt_fire, blocked, rt_allowed, wr_ok, rd_ok;
    logic [AW-1:0]           waddr, raddr;
    logic [AW:0]             occupancy;
    fifo_rt_pkg::occ_flags_t flags;

    rt_recovery #(.RECOVER_CYC(RECOVER_CYC)) u_recovery (
        .clk(clk), .rst_n(rst_n), .rt_n(rt_n), .chain_mode(chain_mode),
        .rt_allowed(rt_allowed), .rt_fire(rt_fire), .blocked(blocked),
        .busy(busy)
    );

    rt_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_en), .rd_req(rd_en),
        .rt_fire(rt_fire), .blocked(blocked), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .waddr(waddr), .raddr(raddr), .occupancy(occupancy),
        .rt_allowed(rt_allowed)
    );

    rt_flag_calc #(.DEPTH(DEPTH), .AE_LEVEL(AE_LEVEL), .AF_LEVEL(AF_LEVEL)) u_flags (
        .occupancy(occupancy), .flags(flags)
    );

    rt_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .waddr(waddr),
        .wdata(wr_data), .rd_ok(rd_ok), .raddr(raddr), .rdata(rd_data)
    );

    assign empty        = flags.empty;
    assign full         = flags.full;
    assign almost_empty = flags.almost_empty;
    assign almost_full  = flags.almost_full;

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !busy)); // R1
    AST_CHAIN_NO_RT: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && !busy) |=> !busy); // R10
endmodule

// File: tb/fifo_rt_ctrl_tb.sv
`timescale 1ns/1ps
module fifo_rt_ctrl_tb;
    localparam int DW = 9, DEPTH = 16, AE = 2, AF = 2, REC = 3;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic rt_n = 1'b1, chain_mode = 1'b0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic busy, empty, full, almost_empty, almost_full;

    int errors = 0, checks = 0;
    int m_wp = 0, m_rp = 0, m_wc = 0, m_bc = 0, m_rd = 0;
    int m_mem [DEPTH];

    always #2 clk = ~clk;

    fifo_rt_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .AE_LEVEL(AE), .AF_LEVEL(AF),
                   .RECOVER_CYC(REC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rt_n(rt_n), .chain_mode(chain_mode),
        .busy(busy), .empty(empty), .full(full), .almost_empty(almost_empty),
        .almost_full(almost_full)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int occ();
        return m_wp - m_rp;
    endfunction

    // Compare every output with the bench model.
    task automatic chk_all();
        chk("R2 rd_data", int'(rd_data), m_rd);
        chk("R4 empty", int'(empty), int'(occ() == 0));
        chk("R4 full", int'(full), int'(occ() == DEPTH));
        chk("R4 almost_empty", int'(almost_empty), int'(occ() <= AE));
        chk("R4 almost_full", int'(almost_full), int'(occ() >= DEPTH - AF));
        chk("R7 busy", int'(busy), int'(m_bc != 0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rt_n = 1'b1;
        @(posedge clk);
        m_wp = 0; m_rp = 0; m_wc = 0; m_bc = 0; m_rd = 0;
        #1;
        chk("R1 empty", int'(empty), 1);
        chk("R1 almost_empty", int'(almost_empty), 1);
        chk("R1 full", int'(full), 0);
        chk("R1 almost_full", int'(almost_full), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One clock with the given inputs; the model follows the requirements.
    task automatic step(bit we, int wd, bit re, bit rtn, bit ch);
        bit fire, blk, wok, rok;
        @(negedge clk);
        wr_en = we; wr_data = DW'(wd); rd_en = re; rt_n = rtn; chain_mode = ch;
        fire = !rtn && !ch && (m_wc <= DEPTH);
        blk  = fire || (m_bc != 0);
        wok  = we && !blk && (occ() != DEPTH);
        rok  = re && !blk && (occ() != 0);
        @(posedge clk);
        if (rok) begin m_rd = m_mem[m_rp % DEPTH]; m_rp++; end
        if (wok) begin
            m_mem[m_wp % DEPTH] = wd % (1 << DW); m_wp++;
            if (m_wc <= DEPTH) m_wc++;
        end
        if (fire) begin m_rp = 0; m_bc = REC; end
        else if (m_bc != 0) m_bc--;
        #1;
        chk_all();
    endtask

    task automatic idle();
        step(0, 0, 0, 1, 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        do_reset();

        // Fill to full, then try to overflow.
        for (int i = 0; i < DEPTH; i++) step(1, i * 7 + 3, 0, 1, 0);
        chk("R4 full after DEPTH writes", int'(full), 1);
        step(1, 500, 0, 1, 0);
        chk("R3 write dropped while full", int'(full), 1);
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 0, 1, 1, 0);
            chk("R2 order", int'(rd_data), i * 7 + 3);
        end
        step(0, 0, 1, 1, 0);
        chk("R3 read dropped while empty", int'(rd_data), (DEPTH - 1) * 7 + 3);

        // Rewind with enables asserted (both must be ignored), then repeated replay.
        for (int pass = 0; pass < 2; pass++) begin
            step(1, 400, 1, 0, 0);
            chk("R6 full after rewind", int'(full), 1);
            chk("R7 busy after rewind", int'(busy), 1);
            step(0, 0, 1, 1, 0);
            chk("R7 read ignored while busy", int'(rd_data), (DEPTH - 1) * 7 + 3);
            for (int k = 1; k < REC; k++) idle();
            chk("R7 busy falls after RECOVER_CYC", int'(busy), 0);
            for (int i = 0; i < DEPTH; i++) begin
                step(0, 0, 1, 1, 0);
                chk("R11 full replay", int'(rd_data), i * 7 + 3);
                if (i == 0) chk("R5 first word after rewind", int'(rd_data), 3);
            end
            chk("R11 empty after replay", int'(empty), 1);
        end

        // Words written after the rewind follow the replay.
        do_reset();
        for (int i = 0; i < 4; i++) step(1, 20 + i, 0, 1, 0);
        step(0, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0);
        step(0, 0, 0, 0, 0);
        chk("R6 occupancy equals writes", int'(almost_empty), 0);
        for (int k = 0; k < REC; k++) idle();
        step(1, 60, 0, 1, 0);
        step(1, 61, 0, 1, 0);
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 1, 1, 0);
            chk("R8 replayed word", int'(rd_data), 20 + i);
        end
        step(0, 0, 1, 1, 0);
        chk("R8 new word 1", int'(rd_data), 60);
        step(0, 0, 1, 1, 0);
        chk("R8 new word 2", int'(rd_data), 61);
        chk("R8 empty when caught up", int'(empty), 1);

        // Too many writes since reset: rewind refused.
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1, i, 0, 1, 0);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 1, 0);
        step(1, 99, 0, 1, 0);
        step(0, 0, 0, 0, 0);
        chk("R9 no busy when refused", int'(busy), 0);
        step(0, 0, 1, 1, 0);
        chk("R9 pointer not rewound", int'(rd_data), 99);

        // Depth-chain strap: rewind refused.
        do_reset();
        for (int i = 0; i < 3; i++) step(1, 40 + i, 0, 1, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0);
        step(0, 0, 0, 0, 1);
        chk("R10 no busy in chain mode", int'(busy), 0);
        chk("R10 stays empty in chain mode", int'(empty), 1);

        // Constrained random traffic.
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 199) == 0) do_reset();
            else step($urandom_range(0, 99) < 55, int'($urandom_range(0, 511)),
                      $urandom_range(0, 99) < 50, $urandom_range(0, 39) != 0,
                      $urandom_range(0, 9) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule